// File: doc/BRIEF.md
# Dual-Mode Parallel ADC Bus Controller

This block is the digital control logic on the device side of a multichannel 8-bit converter that sits on a parallel processor bus. It decodes active-low chip-select, read, write and power-down strobes, a mode select and a 3-bit channel address. From these it drives an 8-bit result bus with an enable, an active-low end-of-conversion interrupt and an open-drain ready status. Toward the conversion core it presents a channel select, a one-cycle start pulse and a wake request. The core returns an 8-bit code for the selected channel on `core_code`.

There are two bus disciplines. In strobe-read mode a single read access starts the conversion. The ready status stalls the host until the result is present. In write-then-read mode a write strobe starts the conversion and its trailing edge freezes the upper nibble. The lower nibble follows after an internal delay, or at once if the host reads early. Tying the write and read strobes together gives a pipelined access that returns the previous result while it launches the next conversion. All inputs are assumed to be synchronous to `clk`. All delays are counted in clock cycles.

Top module: `adc_bus_ctrl`

## Requirements
- R1: While `rst` is high, `int_n`=1, `data_oe`=0, `rdy_low`=0, `err_flag`=0, `core_start`=0 and `core_wake`=0.
- R2: `data_oe` is 1 exactly while `cs_n`=0 and `rd_n`=0. `data_out` always shows the output buffer, whether or not `data_oe` is set.
- R3: With `mode`=0, the first edge where `cs_n` and `rd_n` are both low starts a conversion, and `core_start` is 1 for that one cycle. CONV_CYC edges later the buffer takes the full code and `int_n` goes to 0.
- R4: With `mode`=0, `rdy_low` becomes 1 on the edge that sees `cs_n` fall and returns to 0 when the conversion completes. After any edge that sees `mode`=1, `rdy_low` is 0.
- R5: `int_n` returns to 1 on the edge that sees a rising `cs_n` or a rising `rd_n`.
- R6: With `mode`=1, a falling `wr_n` while `cs_n`=0 starts a conversion. The edge that sees `wr_n` rise loads bits 7:4 of the buffer from the core. INTL_CYC edges later, bits 3:0 are loaded and `int_n` goes to 0.
- R7: With `mode`=1, a falling `rd_n` with `cs_n`=0 during the delay after the `wr_n` rise ends the conversion on that edge: bits 3:0 are loaded and `int_n` goes to 0.
- R8: With `wr_n` and `rd_n` driven together and `cs_n`=0, the low pulse puts the previous result on the bus and starts a new conversion.
- R9: `core_chan` follows `addr` with one cycle of delay while idle and holds the start-edge address during a conversion. Address 7 yields 8'hFF whatever `core_code` is.
- R10: `pwrdn_n`=0 drops `core_wake` on the next edge. After the edge that sees `pwrdn_n`=1, the next WAKE_CYC edges ignore starts, and `core_wake` stays 1 until power-down.
- R11: After the edge where `int_n` falls, a start seen on any of the next ACQ_CYC edges is ignored. A start on the edge after that window is accepted.
- R12: Any start ignored under R10 or R11, or seen while `pwrdn_n`=0, sets `err_flag`. The flag stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 1 | 0 = strobe-read mode, 1 = write-then-read mode |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low (mode 1) |
| pwrdn_n | input | 1 | 0 = shut down |
| addr | input | 3 | Channel address |
| core_code | input | 8 | Code from the conversion core |
| data_out | output | 8 | Output buffer contents |
| data_oe | output | 1 | Result bus enable |
| int_n | output | 1 | End of conversion, active low |
| rdy_low | output | 1 | 1 = pull ready line low (open drain) |
| core_chan | output | 3 | Channel select to the core |
| core_start | output | 1 | One-cycle conversion start |
| core_wake | output | 1 | Power request to the core |
| err_flag | output | 1 | Sticky ignored-start flag |

## Verification
The bench builds the controller with CONV_CYC=4, INTL_CYC=5, WAKE_CYC=6 and ACQ_CYC=3. With timing this short, all eight channels can be swept in both modes, and in write-then-read mode both with and without an early read. The core code is a function of the channel and a seed that changes between the two nibble loads, so the bench can tell which edge sampled which nibble. The small windows also let the bench place a start on the last blocked edge and on the first accepted edge of both the wake interval and the acquisition interval.

// File: rtl/adc_bus_pkg.sv
package adc_bus_pkg;

    localparam int DATA_W = 8;
    localparam int CHAN_W = 3;
    localparam int NIB    = DATA_W / 2;
    localparam logic [CHAN_W-1:0] REF_CHAN = '1;

    typedef enum logic [2:0] {
        ST_OFF,
        ST_WAKE,
        ST_IDLE,
        ST_RCONV,
        ST_WLOW,
        ST_LOPASS
    } seq_state_e;

    typedef struct packed {
        logic cs_fall;
        logic cs_rise;
        logic rd_fall;
        logic rd_rise;
        logic wr_fall;
        logic wr_rise;
        logic sel_fall;
    } pin_edges_t;

    function automatic int max_of(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic logic [DATA_W-1:0] pick_code(input logic [CHAN_W-1:0] ch,
                                                    input logic [DATA_W-1:0] code);
        return (ch == REF_CHAN) ? '1 : code;
    endfunction

endpackage

// File: rtl/adc_pin_edges.sv
module adc_pin_edges
    import adc_bus_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       cs_n,
    input  logic       rd_n,
    input  logic       wr_n,
    output pin_edges_t edges
);
    logic cs_q, rd_q, wr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cs_q <= 1'b1;
            rd_q <= 1'b1;
            wr_q <= 1'b1;
        end else begin
            cs_q <= cs_n;
            rd_q <= rd_n;
            wr_q <= wr_n;
        end
    end

    always_comb begin
        edges.cs_fall  = cs_q & ~cs_n;
        edges.cs_rise  = ~cs_q & cs_n;
        edges.rd_fall  = rd_q & ~rd_n;
        edges.rd_rise  = ~rd_q & rd_n;
        edges.wr_fall  = wr_q & ~wr_n;
        edges.wr_rise  = ~wr_q & wr_n;
        edges.sel_fall = (cs_q | rd_q) & ~(cs_n | rd_n);
    end
endmodule

// File: rtl/adc_cycle_timer.sv
module adc_cycle_timer #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    output logic          active,
    output logic          expire
);
    logic [TW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign active = (cnt_q != '0);
    assign expire = (cnt_q == TW'(1));
endmodule

// File: rtl/adc_bus_seq.sv
module adc_bus_seq
    import adc_bus_pkg::*;
#(
    parameter int TW       = 8,
    parameter int CONV_CYC = 100,
    parameter int INTL_CYC = 60,
    parameter int WAKE_CYC = 90
) (
    input  logic              clk,
    input  logic              rst,
    input  pin_edges_t        edges,
    input  logic              mode,
    input  logic              cs_n,
    input  logic              rd_n,
    input  logic              pwrdn_n,
    input  logic [CHAN_W-1:0] addr,
    input  logic [DATA_W-1:0] core_code,
    input  logic              ph_expire,
    input  logic              acq_active,
    output logic              ph_load,
    output logic [TW-1:0]     ph_val,
    output logic              acq_load,
    output logic [DATA_W-1:0] buf_q,
    output logic              int_q,
    output logic              rdy_q,
    output logic              err_q,
    output logic [CHAN_W-1:0] chan_q,
    output logic              start_q,
    output logic              wake
);
    seq_state_e        st_q, st_d;
    logic [DATA_W-1:0] buf_d, picked;
    logic              int_d, rdy_d, err_d, start_d;
    logic [CHAN_W-1:0] chan_d;
    logic              rd_start, wr_start, want_start, early_rd;

    assign picked     = pick_code(chan_q, core_code);
    assign rd_start   = ~mode & ~cs_n & ~rd_n & edges.sel_fall;
    assign wr_start   = mode & ~cs_n & edges.wr_fall;
    assign want_start = rd_start | wr_start;
    assign early_rd   = edges.rd_fall & ~cs_n;

    always_comb begin
        st_d     = st_q;
        buf_d    = buf_q;
        int_d    = int_q;
        rdy_d    = rdy_q;
        err_d    = err_q;
        chan_d   = chan_q;
        start_d  = 1'b0;
        ph_load  = 1'b0;
        ph_val   = '0;
        acq_load = 1'b0;

        if (edges.cs_rise || edges.rd_rise) int_d = 1'b1;

        if (mode)               rdy_d = 1'b0;
        else if (edges.cs_fall) rdy_d = 1'b1;

        if (!pwrdn_n) begin
            st_d  = ST_OFF;
            rdy_d = 1'b0;
            if (want_start) err_d = 1'b1;
        end else begin
            unique case (st_q)
                ST_OFF: begin
                    st_d    = ST_WAKE;
                    ph_load = 1'b1;
                    ph_val  = TW'(WAKE_CYC);
                    if (want_start) err_d = 1'b1;
                end
                ST_WAKE: begin
                    if (want_start) err_d = 1'b1;
                    if (ph_expire) st_d = ST_IDLE;
                end
                ST_IDLE: begin
                    chan_d = addr;
                    if (want_start) begin
                        if (acq_active) begin
                            err_d = 1'b1;
                        end else begin
                            start_d = 1'b1;
                            if (rd_start) begin
                                st_d    = ST_RCONV;
                                ph_load = 1'b1;
                                ph_val  = TW'(CONV_CYC);
                            end else begin
                                st_d = ST_WLOW;
                            end
                        end
                    end
                end
                ST_RCONV: begin
                    if (ph_expire) begin
                        buf_d    = picked;
                        int_d    = 1'b0;
                        rdy_d    = 1'b0;
                        acq_load = 1'b1;
                        st_d     = ST_IDLE;
                    end
                end
                ST_WLOW: begin
                    if (edges.wr_rise) begin
                        buf_d[DATA_W-1:NIB] = picked[DATA_W-1:NIB];
                        ph_load = 1'b1;
                        ph_val  = TW'(INTL_CYC);
                        st_d    = ST_LOPASS;
                    end
                end
                ST_LOPASS: begin
                    if (early_rd || ph_expire) begin
                        buf_d[NIB-1:0] = picked[NIB-1:0];
                        int_d    = 1'b0;
                        acq_load = 1'b1;
                        st_d     = ST_IDLE;
                    end
                end
                default: st_d = ST_OFF;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= ST_OFF;
            buf_q   <= '0;
            int_q   <= 1'b1;
            rdy_q   <= 1'b0;
            err_q   <= 1'b0;
            chan_q  <= '0;
            start_q <= 1'b0;
        end else begin
            st_q    <= st_d;
            buf_q   <= buf_d;
            int_q   <= int_d;
            rdy_q   <= rdy_d;
            err_q   <= err_d;
            chan_q  <= chan_d;
            start_q <= start_d;
        end
    end

    assign wake = (st_q != ST_OFF);
endmodule

// File: rtl/adc_bus_ctrl.sv
module adc_bus_ctrl
    import adc_bus_pkg::*;
#(
    parameter int CONV_CYC = 100,
    parameter int INTL_CYC = 60,
    parameter int WAKE_CYC = 90,
    parameter int ACQ_CYC  = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mode,
    input  logic              cs_n,
    input  logic              rd_n,
    input  logic              wr_n,
    input  logic              pwrdn_n,
    input  logic [CHAN_W-1:0] addr,
    input  logic [DATA_W-1:0] core_code,
    output logic [DATA_W-1:0] data_out,
    output logic              data_oe,
    output logic              int_n,
    output logic              rdy_low,
    output logic [CHAN_W-1:0] core_chan,
    output logic              core_start,
    output logic              core_wake,
    output logic              err_flag
);
    localparam int MAX_CYC = max_of(max_of(CONV_CYC, INTL_CYC), max_of(WAKE_CYC, ACQ_CYC));
    localparam int TW      = $clog2(MAX_CYC + 1);

    pin_edges_t    edges;
    logic          ph_load, ph_active, ph_expire;
    logic [TW-1:0] ph_val;
    logic          acq_load, acq_active, acq_expire;

    adc_pin_edges u_edges (
        .clk   (clk),
        .rst   (rst),
        .cs_n  (cs_n),
        .rd_n  (rd_n),
        .wr_n  (wr_n),
        .edges (edges)
    );

    adc_cycle_timer #(.TW(TW)) u_phase_tmr (
        .clk      (clk),
        .rst      (rst),
        .load     (ph_load),
        .load_val (ph_val),
        .active   (ph_active),
        .expire   (ph_expire)
    );

    adc_cycle_timer #(.TW(TW)) u_acq_tmr (
        .clk      (clk),
        .rst      (rst),
        .load     (acq_load),
        .load_val (TW'(ACQ_CYC)),
        .active   (acq_active),
        .expire   (acq_expire)
    );

    adc_bus_seq #(
        .TW       (TW),
        .CONV_CYC (CONV_CYC),
        .INTL_CYC (INTL_CYC),
        .WAKE_CYC (WAKE_CYC)
    ) u_seq (
        .clk        (clk),
        .rst        (rst),
        .edges      (edges),
        .mode       (mode),
        .cs_n       (cs_n),
        .rd_n       (rd_n),
        .pwrdn_n    (pwrdn_n),
        .addr       (addr),
        .core_code  (core_code),
        .ph_expire  (ph_expire & ph_active),
        .acq_active (acq_active | acq_expire),
        .ph_load    (ph_load),
        .ph_val     (ph_val),
        .acq_load   (acq_load),
        .buf_q      (data_out),
        .int_q      (int_n),
        .rdy_q      (rdy_low),
        .err_q      (err_flag),
        .chan_q     (core_chan),
        .start_q    (core_start),
        .wake       (core_wake)
    );

    assign data_oe = ~cs_n & ~rd_n;
endmodule

// File: rtl/adc_bus_ctrl_chk.sv
module adc_bus_ctrl_chk (
    input logic clk,
    input logic rst,
    input logic mode,
    input logic pwrdn_n,
    input logic core_start,
    input logic core_wake,
    input logic err_flag,
    input logic rdy_low
);
    assert_sleep_drop_R10: assert property (@(posedge clk) disable iff (rst)
        !pwrdn_n |=> !core_wake);

    assert_err_sticky_R12: assert property (@(posedge clk) disable iff (rst)
        err_flag |=> err_flag);

    assert_start_awake_R3: assert property (@(posedge clk) disable iff (rst)
        core_start |-> core_wake);

    assert_start_single_R3: assert property (@(posedge clk) disable iff (rst)
        core_start |=> !core_start);

    assert_rdy_quiet_R4: assert property (@(posedge clk) disable iff (rst)
        mode |=> !rdy_low);
endmodule

bind adc_bus_ctrl adc_bus_ctrl_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .mode       (mode),
    .pwrdn_n    (pwrdn_n),
    .core_start (core_start),
    .core_wake  (core_wake),
    .err_flag   (err_flag),
    .rdy_low    (rdy_low)
);

// File: tb/test_adc_bus_ctrl.sv
module test_adc_bus_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int CONV = 4;
    localparam int INTL = 5;
    localparam int WAKE = 6;
    localparam int ACQ  = 3;

    logic       clk = 1'b0;
    logic       rst, mode, cs_n, rd_n, wr_n, pwrdn_n;
    logic [2:0] addr;
    logic [7:0] seed;
    logic [7:0] core_code, data_out;
    logic       data_oe, int_n, rdy_low, core_start, core_wake, err_flag;
    logic [2:0] core_chan;
    int total = 0;
    int bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign core_code = ({5'd0, core_chan} * 8'd37) + seed;

    adc_bus_ctrl #(
        .CONV_CYC (CONV),
        .INTL_CYC (INTL),
        .WAKE_CYC (WAKE),
        .ACQ_CYC  (ACQ)
    ) i_adc_bus_ctrl (
        .clk(clk), .rst(rst), .mode(mode), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
        .pwrdn_n(pwrdn_n), .addr(addr), .core_code(core_code), .data_out(data_out),
        .data_oe(data_oe), .int_n(int_n), .rdy_low(rdy_low), .core_chan(core_chan),
        .core_start(core_start), .core_wake(core_wake), .err_flag(err_flag)
    );

    function automatic logic [7:0] expv(input logic [2:0] a, input logic [7:0] s);
        return (a == 3'd7) ? 8'hFF : 8'(int'(a) * 37 + int'(s));
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset(input logic m);
        rst = 1'b1; mode = m; cs_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1;
        pwrdn_n = 1'b1; addr = 3'd0; seed = 8'd0;
        tick(2);
        rst = 1'b0;
        tick(WAKE + 2);
    endtask

    task automatic rd_conv(input logic [2:0] a, input logic [7:0] s);
        logic [7:0] e;
        e = expv(a, s);
        addr = a; seed = s; tick(2);
        cs_n = 1'b0; rd_n = 1'b0; tick(1);
        chk("R3 start pulse", core_start, 1);
        chk("R4 rdy asserted", rdy_low, 1);
        chk("R2 oe both low", data_oe, 1);
        addr = a ^ 3'd5;
        tick(CONV - 1);
        chk("R3 int pending", int_n, 1);
        chk("R9 channel held", core_chan, a);
        tick(1);
        chk("R3 int low at end", int_n, 0);
        chk("R9 result code", data_out, e);
        chk("R4 rdy released", rdy_low, 0);
        rd_n = 1'b1; tick(1);
        chk("R5 int cleared by rd rise", int_n, 1);
        chk("R2 oe off", data_oe, 0);
        cs_n = 1'b1; addr = a; tick(ACQ + 1);
    endtask

    task automatic wr_conv(input logic [2:0] a, input logic [7:0] s1, input logic [7:0] s2,
                           input bit early);
        logic [7:0] e1, e2;
        e1 = expv(a, s1); e2 = expv(a, s2);
        addr = a; seed = s1; tick(2);
        cs_n = 1'b0; wr_n = 1'b0; tick(1);
        chk("R6 start pulse", core_start, 1);
        chk("R2 oe off on write", data_oe, 0);
        chk("R4 rdy quiet in mode 1", rdy_low, 0);
        wr_n = 1'b1; tick(1);
        chk("R6 upper nibble", data_out[7:4], e1[7:4]);
        seed = s2;
        if (early) begin
            rd_n = 1'b0; tick(1);
            chk("R7 int after early read", int_n, 0);
            chk("R7 result", data_out, {e1[7:4], e2[3:0]});
        end else begin
            tick(INTL - 1);
            chk("R6 int pending", int_n, 1);
            tick(1);
            chk("R6 int low", int_n, 0);
            rd_n = 1'b0; tick(1);
            chk("R6 result", data_out, {e1[7:4], e2[3:0]});
            chk("R2 oe on read", data_oe, 1);
        end
        cs_n = 1'b1; tick(1);
        chk("R5 int cleared by cs rise", int_n, 1);
        rd_n = 1'b1; tick(ACQ + 1);
    endtask

    // read-mode conversion that leaves the bench right after INT falls
    task automatic rd_to_int(input logic [2:0] a);
        addr = a; seed = 8'd3; tick(2);
        cs_n = 1'b0; rd_n = 1'b0; tick(CONV + 1);
    endtask

    initial begin
        logic [7:0] prev;
        rst = 1'b1; mode = 1'b0; cs_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1;
        pwrdn_n = 1'b1; addr = 3'd0; seed = 8'd0;
        tick(1);
        chk("R1 int_n", int_n, 1);
        chk("R1 data_oe", data_oe, 0);
        chk("R1 rdy_low", rdy_low, 0);
        chk("R1 err_flag", err_flag, 0);
        chk("R1 core_wake", core_wake, 0);
        chk("R1 core_start", core_start, 0);

        // R3 R4 R9: strobe-read sweep
        do_reset(1'b0);
        for (int ch = 0; ch < 8; ch++) begin
            rd_conv(3'(ch), 8'd11);
            rd_conv(3'(ch), 8'd200);
        end
        cs_n = 1'b0; tick(1);
        chk("R2 oe cs only", data_oe, 0);
        chk("R4 rdy on cs fall", rdy_low, 1);
        cs_n = 1'b1; tick(1);

        // R6 R7: write-then-read sweep
        do_reset(1'b1);
        for (int ch = 0; ch < 8; ch++) begin
            wr_conv(3'(ch), 8'd5, 8'd90, 1'b0);
            wr_conv(3'(ch), 8'd17, 8'd130, 1'b1);
        end
        chk("R12 no error after legal use", err_flag, 0);

        // R8: pipelined strobes
        wr_conv(3'd2, 8'd40, 8'd40, 1'b0);
        prev = expv(3'd2, 8'd40);
        cs_n = 1'b0;
        for (int k = 0; k < 6; k++) begin
            addr = 3'((k * 3) % 8); seed = 8'(k * 29); tick(2);
            wr_n = 1'b0; rd_n = 1'b0; tick(1);
            chk("R8 previous result", data_out, prev);
            chk("R8 oe", data_oe, 1);
            chk("R8 start", core_start, 1);
            wr_n = 1'b1; rd_n = 1'b1; tick(INTL + 1);
            prev = expv(3'((k * 3) % 8), 8'(k * 29));
            chk("R8 new result", data_out, prev);
            chk("R8 int low", int_n, 0);
            tick(ACQ + 1);
        end
        cs_n = 1'b1; tick(2);

        // R10 R12: start while powered down
        do_reset(1'b0);
        prev = data_out;
        pwrdn_n = 1'b0; tick(1);
        chk("R10 wake dropped", core_wake, 0);
        cs_n = 1'b0; rd_n = 1'b0; tick(1);
        chk("R10 no start when down", core_start, 0);
        tick(CONV + 1);
        chk("R10 int untouched", int_n, 1);
        chk("R10 buffer untouched", data_out, prev);
        chk("R12 error raised", err_flag, 1);
        cs_n = 1'b1; rd_n = 1'b1; pwrdn_n = 1'b1; tick(WAKE + 2);
        rd_conv(3'd1, 8'd7);
        chk("R12 error sticky", err_flag, 1);

        // R10: last blocked edge of the wake window
        do_reset(1'b0);
        pwrdn_n = 1'b0; tick(2);
        pwrdn_n = 1'b1; tick(1);
        chk("R10 wake raised", core_wake, 1);
        tick(WAKE - 1);
        cs_n = 1'b0; rd_n = 1'b0; tick(1);
        chk("R10 start ignored in wake", core_start, 0);
        chk("R12 wake error", err_flag, 1);
        cs_n = 1'b1; rd_n = 1'b1; tick(1);

        // R10: first accepted edge after wake
        do_reset(1'b0);
        pwrdn_n = 1'b0; tick(2);
        pwrdn_n = 1'b1; tick(1);
        tick(WAKE);
        cs_n = 1'b0; rd_n = 1'b0; tick(1);
        chk("R10 start after wake", core_start, 1);
        chk("R12 no error", err_flag, 0);
        tick(CONV);
        cs_n = 1'b1; rd_n = 1'b1; tick(ACQ + 1);

        // R11: last blocked edge of acquisition
        do_reset(1'b0);
        rd_to_int(3'd4);
        chk("R11 int fell", int_n, 0);
        rd_n = 1'b1; tick(1);
        tick(ACQ - 2);
        rd_n = 1'b0; tick(1);
        chk("R11 start blocked", core_start, 0);
        chk("R12 acq error", err_flag, 1);
        cs_n = 1'b1; rd_n = 1'b1; tick(CONV + 2);
        chk("R11 no conversion", int_n, 1);

        // R11: first accepted edge after acquisition
        do_reset(1'b0);
        rd_to_int(3'd4);
        rd_n = 1'b1; tick(1);
        tick(ACQ - 1);
        rd_n = 1'b0; tick(1);
        chk("R11 start accepted", core_start, 1);
        chk("R12 no acq error", err_flag, 0);
        cs_n = 1'b1; rd_n = 1'b1; tick(CONV + 2);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule